// File: doc/BRIEF.md
# Endpoint DMA Handshake Controller

This block paces single-address DMA transfers between the double-buffered main data endpoint (endpoint 2) and local memory. An external DMA controller watches one request output. It answers with an active-low acknowledge and an active-low read or write strobe for each byte. It may also pull an active-low end-of-transfer line to stop the transfer early. Each qualified strobe becomes a one-cycle pulse towards the endpoint buffer: a pop when the buffer is drained into memory, a push when memory fills the buffer.

A single configuration byte sets the behaviour. It holds the burst size, the direction, the enable, auto-reload, the interrupt pin mode and two interrupt enables for neighbouring endpoints. The register is reached by first issuing command code 0xFB and then reading or writing one data byte. The request rises only while DMA is enabled and the active buffer can serve the selected direction. It drops after the last byte of each burst and rises again if the buffer can still serve.

Top module: `ep_dma_hs`

## Requirements
- R1: After a synchronous reset the configuration byte is 0x00, `dma_req` is low, and `rd_data` reads 0x00.
- R2: A `cmd_valid` cycle with code 0xFB selects the configuration byte. Any other code deselects it. While the byte is selected, `wr_valid` loads `wr_data` into it and `rd_data` shows it. While it is deselected, `rd_data` is 0x00 and writes leave the byte unchanged.
- R3: Configuration bit 7 drives `irq_en_ep5`, bit 6 drives `irq_en_ep4`, bit 5 drives `irq_pin_mode` and bit 3 drives `dma_dir`.
- R4: `dma_req` can be high only while bit 2 (enable) is set and the buffer is ready. With bit 3 = 0 (endpoint to memory, read strobes), ready means `buf_has_data`. With bit 3 = 1 (memory to endpoint, write strobes), ready means `buf_has_space`. The request rises within two cycles once both conditions hold.
- R5: Bits 1:0 set the burst size: 00 = 1, 01 = 4, 10 = 8, 11 = 16 bytes per request. `dma_req` stays high until that many bytes have moved. It is low in the cycle after the last byte and rises again within three cycles if the buffer is still ready.
- R6: A byte moves when `dma_ack_n` is low and the strobe for the active direction falls. This gives a one-cycle `buf_pop` when bit 3 = 0 and a one-cycle `buf_push` when bit 3 = 1. The strobe for the other direction has no effect.
- R7: End-of-transfer is valid only when `dma_ack_n`, the strobe for the active direction and `dma_eot_n` are all low in the same cycle. `dma_eot_n` low under any other combination is ignored.
- R8: A valid end-of-transfer drops `dma_req` and clears bit 2, unless bit 4 (auto-reload) is set. A register write in the same cycle takes priority over the clear.
- R9: When auto-reload is set, a valid end-of-transfer keeps bit 2 set. `dma_req` then stays low until the ready input has been seen low, and rises again once it returns high.
- R10: Clearing bit 2 in the middle of a burst drops `dma_req` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Command code |
| wr_valid | input | 1 | Data byte write strobe |
| wr_data | input | 8 | Data byte to write |
| rd_data | output | 8 | Selected register value, 0 when not selected |
| buf_has_data | input | 1 | Active endpoint buffer holds bytes |
| buf_has_space | input | 1 | Active endpoint buffer has free room |
| dma_req | output | 1 | DMA request |
| dma_ack_n | input | 1 | DMA acknowledge, active low |
| dma_rd_n | input | 1 | Read strobe, active low |
| dma_wr_n | input | 1 | Write strobe, active low |
| dma_eot_n | input | 1 | End of transfer, active low |
| buf_pop | output | 1 | One byte taken from the buffer |
| buf_push | output | 1 | One byte placed in the buffer |
| irq_en_ep4 | output | 1 | Interrupt enable, endpoint 4 |
| irq_en_ep5 | output | 1 | Interrupt enable, endpoint 5 |
| irq_pin_mode | output | 1 | Interrupt pin mode |
| dma_dir | output | 1 | Current DMA direction |

## Verification
The bench runs each burst size and counts the strobes until the request falls. A counter that is off by one would withdraw the request one byte early or late. It pulses the strobe of the wrong direction, and pulls end-of-transfer low without an acknowledge or without a strobe. A design that mixes up the strobes, or that qualifies end-of-transfer on fewer than three signals, would consume a byte or clear the enable there. It also checks the auto-reload case, where a design that ignores the reload bit would lose the enable or raise the request again on the same buffer. Finally, it checks that writes made while another command is selected do not reach the register.

// File: rtl/ep_dma_pkg.sv
package ep_dma_pkg;
    localparam int          BYTE_W      = 8;
    localparam int          BEAT_W      = 5;
    localparam logic [7:0]  CMD_DMA_CFG = 8'hFB;

    typedef struct packed {
        logic       irq_ep5;
        logic       irq_ep4;
        logic       irq_pin;
        logic       reload;
        logic       dir;
        logic       en;
        logic [1:0] burst;
    } dma_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_GAP,
        ST_RELOAD
    } req_st_t;

    function automatic logic [BEAT_W-1:0] burst_beats(input logic [1:0] code);
        case (code)
            2'b00:   burst_beats = BEAT_W'(1);
            2'b01:   burst_beats = BEAT_W'(4);
            2'b10:   burst_beats = BEAT_W'(8);
            default: burst_beats = BEAT_W'(16);
        endcase
    endfunction
endpackage

// File: rtl/ep_dma_cfg_reg.sv
module ep_dma_cfg_reg
    import ep_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [BYTE_W-1:0] cmd_code,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              eot_valid,
    output dma_cfg_t          cfg,
    output logic [BYTE_W-1:0] rd_data
);
    logic sel_q;
    logic wr_hit;

    assign wr_hit  = wr_valid && sel_q;
    assign rd_data = sel_q ? BYTE_W'(cfg) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
            cfg   <= '0;
        end else begin
            if (cmd_valid)
                sel_q <= (cmd_code == CMD_DMA_CFG);
            if (wr_hit)
                cfg <= dma_cfg_t'(wr_data);
            else if (eot_valid && !cfg.reload)
                cfg.en <= 1'b0;
        end
    end

    // R8: a valid end-of-transfer without reload leaves DMA disabled
    p_eot_clears_en_r8: assert property (@(posedge clk) disable iff (rst)
        (eot_valid && !cfg.reload && !wr_hit) |=> !cfg.en);

    // R2: writes while deselected leave the byte unchanged
    p_no_write_deselected_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !sel_q && !eot_valid) |=> $stable(cfg));
endmodule

// File: rtl/ep_dma_qual.sv
module ep_dma_qual (
    input  logic clk,
    input  logic rst,
    input  logic dir,
    input  logic ack_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic eot_n,
    output logic beat,
    output logic eot_valid
);
    logic stb_n;
    logic stb_prev_q;

    assign stb_n     = dir ? wr_n : rd_n;
    assign beat      = !ack_n && !stb_n && stb_prev_q;
    assign eot_valid = !ack_n && !stb_n && !eot_n;

    always_ff @(posedge clk) begin
        if (rst) stb_prev_q <= 1'b1;
        else     stb_prev_q <= stb_n;
    end

    // R6: a byte is counted once per strobe, never on two cycles in a row
    p_beat_once_r6: assert property (@(posedge clk) disable iff (rst)
        beat |=> !beat);
endmodule

// File: rtl/ep_dma_req_fsm.sv
module ep_dma_req_fsm
    import ep_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       ready,
    input  logic       reload,
    input  logic [1:0] burst,
    input  logic       beat,
    input  logic       eot_valid,
    output logic       req
);
    req_st_t             st_q;
    logic [BEAT_W-1:0]   cnt_q;
    logic [BEAT_W-1:0]   len;
    logic                last_beat;

    assign len       = burst_beats(burst);
    assign last_beat = (cnt_q == len - BEAT_W'(1));
    assign req       = (st_q == ST_ACTIVE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else if (eot_valid) begin
            st_q  <= reload ? ST_RELOAD : ST_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (en && ready) st_q <= ST_ACTIVE;
                end
                ST_ACTIVE: begin
                    if (!en || !ready) begin
                        st_q  <= ST_IDLE;
                        cnt_q <= '0;
                    end else if (beat) begin
                        if (last_beat) begin
                            st_q  <= ST_GAP;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + BEAT_W'(1);
                        end
                    end
                end
                ST_GAP:    st_q <= ST_IDLE;
                default:   if (!ready) st_q <= ST_IDLE;
            endcase
        end
    end

    // R4: no request in a cycle after the enable was low
    p_req_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> !req);

    // R5: the beat counter stays inside the burst
    p_burst_bound_r5: assert property (@(posedge clk) disable iff (rst)
        req |-> (cnt_q < len));

    // R5: the request is withdrawn after the last byte of a burst
    p_drop_after_last_r5: assert property (@(posedge clk) disable iff (rst)
        (req && beat && last_beat) |=> !req);
endmodule

// File: rtl/ep_dma_hs.sv
module ep_dma_hs
    import ep_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [BYTE_W-1:0] cmd_code,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              buf_has_data,
    input  logic              buf_has_space,
    output logic              dma_req,
    input  logic              dma_ack_n,
    input  logic              dma_rd_n,
    input  logic              dma_wr_n,
    input  logic              dma_eot_n,
    output logic              buf_pop,
    output logic              buf_push,
    output logic              irq_en_ep4,
    output logic              irq_en_ep5,
    output logic              irq_pin_mode,
    output logic              dma_dir
);
    dma_cfg_t cfg;
    logic     beat;
    logic     eot_valid;
    logic     ready;

    ep_dma_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .eot_valid (eot_valid),
        .cfg       (cfg),
        .rd_data   (rd_data)
    );

    ep_dma_qual u_qual (
        .clk       (clk),
        .rst       (rst),
        .dir       (cfg.dir),
        .ack_n     (dma_ack_n),
        .rd_n      (dma_rd_n),
        .wr_n      (dma_wr_n),
        .eot_n     (dma_eot_n),
        .beat      (beat),
        .eot_valid (eot_valid)
    );

    assign ready = cfg.dir ? buf_has_space : buf_has_data;

    ep_dma_req_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg.en),
        .ready     (ready),
        .reload    (cfg.reload),
        .burst     (cfg.burst),
        .beat      (beat),
        .eot_valid (eot_valid),
        .req       (dma_req)
    );

    assign buf_pop      = beat && !cfg.dir;
    assign buf_push     = beat &&  cfg.dir;
    assign irq_en_ep4   = cfg.irq_ep4;
    assign irq_en_ep5   = cfg.irq_ep5;
    assign irq_pin_mode = cfg.irq_pin;
    assign dma_dir      = cfg.dir;

    // R6: a byte goes one way only
    p_one_direction_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({buf_pop, buf_push}));

    // R4: a request in a cycle after the buffer was not ready is impossible
    p_req_needs_ready_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(ready) |-> !dma_req);
endmodule

// File: tb/test_ep_dma_hs.sv
module test_ep_dma_hs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       buf_has_data = 1'b0;
    logic       buf_has_space = 1'b0;
    logic       dma_req;
    logic       dma_ack_n = 1'b1;
    logic       dma_rd_n = 1'b1;
    logic       dma_wr_n = 1'b1;
    logic       dma_eot_n = 1'b1;
    logic       buf_pop, buf_push;
    logic       irq_en_ep4, irq_en_ep5, irq_pin_mode, dma_dir;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ep_dma_hs i_ep_dma_hs (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_data(rd_data),
        .buf_has_data(buf_has_data), .buf_has_space(buf_has_space),
        .dma_req(dma_req), .dma_ack_n(dma_ack_n), .dma_rd_n(dma_rd_n),
        .dma_wr_n(dma_wr_n), .dma_eot_n(dma_eot_n), .buf_pop(buf_pop),
        .buf_push(buf_push), .irq_en_ep4(irq_en_ep4), .irq_en_ep5(irq_en_ep5),
        .irq_pin_mode(irq_pin_mode), .dma_dir(dma_dir)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    task automatic send_cmd(input logic [7:0] code);
        @(negedge clk); cmd_valid = 1'b1; cmd_code = code;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] val);
        @(negedge clk); wr_valid = 1'b1; wr_data = val;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic set_cfg(input logic [7:0] val);
        send_cmd(8'hFB);
        write_byte(val);
    endtask

    task automatic wait_req(input string tag, input int limit);
        int n = 0;
        while (!dma_req && n < limit) begin
            @(negedge clk); n++;
        end
        check(tag, dma_req, 1);
    endtask

    task automatic strobe(input bit use_wr, input bit ack, input bit eot, input bit stb);
        @(negedge clk);
        dma_ack_n = ~ack; dma_eot_n = ~eot;
        if (use_wr) dma_wr_n = ~stb; else dma_rd_n = ~stb;
        #1;
    endtask

    task automatic release_bus();
        @(negedge clk);
        dma_ack_n = 1'b1; dma_rd_n = 1'b1; dma_wr_n = 1'b1; dma_eot_n = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 req after reset", dma_req, 0);
        check("R1 rd_data deselected", rd_data, 8'h00);
        send_cmd(8'hFB);
        check("R1 cfg after reset", rd_data, 8'h00);
    endtask

    task automatic t_register();
        set_cfg(8'hE0);
        check("R2 readback", rd_data, 8'hE0);
        check("R3 irq ep5 bit7", irq_en_ep5, 1);
        check("R3 irq ep4 bit6", irq_en_ep4, 1);
        check("R3 pin mode bit5", irq_pin_mode, 1);
        send_cmd(8'hF0);
        check("R2 other code reads zero", rd_data, 8'h00);
        write_byte(8'h55);
        send_cmd(8'hFB);
        check("R2 deselected write ignored", rd_data, 8'hE0);
        set_cfg(8'h48);
        check("R3 ep5 cleared", irq_en_ep5, 0);
        check("R3 ep4 set", irq_en_ep4, 1);
        check("R3 dir bit3", dma_dir, 1);
        set_cfg(8'h00);
    endtask

    task automatic t_ready_gate();
        buf_has_data = 1'b0; buf_has_space = 1'b1;
        set_cfg(8'h04);
        repeat (3) @(negedge clk);
        check("R4 no req without data (read dir)", dma_req, 0);
        buf_has_data = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R4 req with data (read dir)", dma_req, 1);
        buf_has_space = 1'b0;
        set_cfg(8'h0C);
        repeat (3) @(negedge clk);
        check("R4 no req without space (write dir)", dma_req, 0);
        buf_has_space = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R4 req with space (write dir)", dma_req, 1);
        set_cfg(8'h00);
        @(negedge clk);
        check("R4 no req when disabled", dma_req, 0);
    endtask

    task automatic t_burst(input logic [1:0] code, input int n, input bit wdir);
        int moved = 0;
        buf_has_data = 1'b1; buf_has_space = 1'b1;
        set_cfg({4'b0000, wdir, 1'b1, code});
        wait_req("R5 req at burst start", 5);
        for (int i = 0; i < n; i++) begin
            check("R5 req held inside burst", dma_req, 1);
            strobe(wdir, 1'b1, 1'b0, 1'b1);
            if (wdir) begin
                moved += int'(buf_push);
                check("R6 no pop in write dir", buf_pop, 0);
            end else begin
                moved += int'(buf_pop);
                check("R6 no push in read dir", buf_push, 0);
            end
            release_bus();
        end
        check("R6 byte pulses per burst", moved, n);
        check("R5 req dropped after last byte", dma_req, 0);
        wait_req("R5 req reasserted", 4);
        set_cfg(8'h00);
    endtask

    task automatic t_wrong_strobe();
        buf_has_data = 1'b1;
        set_cfg(8'h04);
        wait_req("R6 req before wrong strobe", 5);
        strobe(1'b1, 1'b1, 1'b0, 1'b1);
        check("R6 wrong strobe no pop", buf_pop, 0);
        check("R6 wrong strobe no push", buf_push, 0);
        release_bus();
        @(negedge clk);
        check("R6 burst not consumed by wrong strobe", dma_req, 1);
        set_cfg(8'h00);
    endtask

    task automatic t_eot();
        buf_has_data = 1'b1;
        set_cfg(8'h07);
        wait_req("R8 req before eot", 5);
        strobe(1'b0, 1'b0, 1'b1, 1'b1);
        release_bus();
        check("R7 eot without ack keeps enable", rd_data[2], 1);
        dma_rd_n = 1'b1;
        strobe(1'b0, 1'b1, 1'b1, 1'b0);
        release_bus();
        check("R7 eot without strobe keeps enable", rd_data[2], 1);
        check("R7 req kept after ignored eot", dma_req, 1);
        strobe(1'b0, 1'b1, 1'b1, 1'b1);
        release_bus();
        check("R8 eot drops req", dma_req, 0);
        check("R8 eot clears enable", rd_data, 8'h03);
        repeat (3) @(negedge clk);
        check("R8 req stays low after eot", dma_req, 0);
    endtask

    task automatic t_reload();
        buf_has_data = 1'b1;
        set_cfg(8'h17);
        wait_req("R9 req before eot", 5);
        strobe(1'b0, 1'b1, 1'b1, 1'b1);
        release_bus();
        check("R9 reload keeps enable", rd_data, 8'h17);
        repeat (4) @(negedge clk);
        check("R9 req low on same buffer", dma_req, 0);
        buf_has_data = 1'b0;
        @(negedge clk); @(negedge clk);
        buf_has_data = 1'b1;
        wait_req("R9 req resumes on next buffer", 4);
        set_cfg(8'h00);
    endtask

    task automatic t_disable_mid();
        buf_has_data = 1'b1;
        set_cfg(8'h07);
        wait_req("R10 req before disable", 5);
        strobe(1'b0, 1'b1, 1'b0, 1'b1);
        release_bus();
        check("R10 req mid burst", dma_req, 1);
        @(negedge clk); wr_valid = 1'b1; wr_data = 8'h03;
        @(negedge clk); wr_valid = 1'b0;
        @(negedge clk);
        check("R10 req dropped after disable", dma_req, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_register();
        t_ready_gate();
        t_burst(2'b00, 1, 1'b0);
        t_burst(2'b01, 4, 1'b0);
        t_burst(2'b10, 8, 1'b1);
        t_burst(2'b11, 16, 1'b0);
        t_wrong_strobe();
        t_eot();
        t_reload();
        t_disable_mid();
        finish_run();
    end
endmodule